// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a small byte-wide NOR-style flash array. It watches single-cycle bus writes, each with an address and a data byte. It recognises multi-write unlock sequences and from them starts byte programming, chip erase or sector erase, or enters an identification mode. The storage is an internal byte array. Program and erase run for a parameterised number of busy cycles. While one of them runs, reads return a polling status byte in place of array data.

Reads are synchronous: a read strobe samples the address, and the byte appears on `rdata_o` after the next clock edge. The output holds its value until the next read. The sector number is the top `SECT_W` address bits. With the defaults (11 address bits, 3 sector bits) there are 8 sectors of 256 bytes. Command addresses are compared on address bits [10:0]. The array resets to all FFh.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `rdata_o` is 00h and every array byte reads FFh. A read strobe in cycle n makes `rdata_o` show the selected byte after edge n, and `rdata_o` keeps its value in cycles with no read strobe.
- R2: The program command is four writes: AAh to 555h, 55h to 2AAh, A0h to 555h, then any data to any address, which is taken as the target. From the cycle after that write, the operation is busy for exactly `PROG_CYC` cycles. At the end of that time the target byte is updated and the decoder returns to read mode.
- R3: Programming stores old AND new, so it can clear bits but never set them.
- R4: The identification command is AAh to 555h, 55h to 2AAh, then 90h to 555h. In this mode a read at low byte 00h returns `MFR_ID` and at 01h returns `DEV_ID`. At 02h it returns 01h if bit s of `SECT_PROT` is set for the addressed sector s, otherwise 00h. Any other low byte returns 00h. Only F0h leaves the mode; all other writes are ignored.
- R5: Chip erase is AAh/555h, 55h/2AAh, 80h/555h, AAh/555h, 55h/2AAh, then 10h to 555h. After `ERASE_CYC` busy cycles every byte is FFh.
- R6: Sector erase uses the same six writes but ends with 30h to any address. After `ERASE_CYC` busy cycles every byte of that address's sector is FFh, and the other sectors are unchanged.
- R7: During an unfinished sequence, a write with the wrong address or data (including F0h) returns the decoder to read mode and leaves the array unchanged. In read mode, writes other than AAh to 555h do nothing.
- R8: A read of any address while busy returns a status byte instead of array data. Bit 7 is the complement of the target's bit 7: ~data[7] for program, 0 for erase. Bit 6 is 0 on the first status read of an operation and flips on each later status read. Bit 5 is the timeout flag, and bits 4:0 are 0.
- R9: Writing B0h during a sector erase suspends it. While suspended, the remaining busy count is frozen and reads return array data. Writing 30h resumes the erase with the count it had; other writes are ignored.
- R10: A high `tmo_force_i` while busy puts the decoder in a failed state. Status reads then show bit 5 = 1, and writes other than F0h are ignored. F0h returns to read mode, and the aborted operation leaves the array unchanged.
- R11: If completion and `tmo_force_i` fall in the same cycle, completion wins: the array is updated and no failure is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte address for reads and writes |
| wdata_i | input | 8 | Write data / command byte |
| tmo_force_i | input | 1 | Forces the time-limit failure of a running operation |
| rdata_o | output | 8 | Registered read data or status byte |

## Verification
The last busy cycle of an operation can also carry a forced timeout. The bench provokes this by counting cycles from the final program write and raising `tmo_force_i` in exactly the cycle where the busy count ends. It judges the result by reading the target byte afterwards, which must hold the programmed value and not the pre-program value. A read placed in the last busy cycle must likewise return the status byte, because reads see the state before the edge. This is checked through the reference model on every cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  parameter int unsigned CMD_AW = 11;
  parameter logic [CMD_AW-1:0] ADR_A = 11'h555;
  parameter logic [CMD_AW-1:0] ADR_B = 11'h2AA;

  parameter logic [7:0] K_UNL1  = 8'hAA;
  parameter logic [7:0] K_UNL2  = 8'h55;
  parameter logic [7:0] K_IDENT = 8'h90;
  parameter logic [7:0] K_PROG  = 8'hA0;
  parameter logic [7:0] K_ERASE = 8'h80;
  parameter logic [7:0] K_CHIP  = 8'h10;
  parameter logic [7:0] K_SECT  = 8'h30;
  parameter logic [7:0] K_SUSP  = 8'hB0;
  parameter logic [7:0] K_RESET = 8'hF0;

  typedef enum logic [3:0] {
    ST_READ, ST_U1, ST_U2, ST_PARM, ST_E1, ST_E2, ST_E3,
    ST_IDENT, ST_PBUSY, ST_EBUSY, ST_ESUSP, ST_FAIL
  } fcd_state_e;
endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == CNT_W'(1));
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              tmo_force_i,
  input  logic              done_i,
  output fcd_state_e        state_o,
  output logic              start_prog_o,
  output logic              start_erase_o,
  output logic              run_o,
  output logic              op_erase_o,
  output logic              op_chip_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [7:0]        tgt_data_o
);
  fcd_state_e st_q, st_d;
  logic chip_d;
  logic hit_a, hit_b;

  assign hit_a = (addr_i[CMD_AW-1:0] == ADR_A);
  assign hit_b = (addr_i[CMD_AW-1:0] == ADR_B);

  always_comb begin
    st_d          = st_q;
    start_prog_o  = 1'b0;
    start_erase_o = 1'b0;
    chip_d        = 1'b0;
    unique case (st_q)
      ST_READ:  if (wr_en_i && hit_a && wdata_i == K_UNL1) st_d = ST_U1;
      ST_U1:    if (wr_en_i) st_d = (hit_b && wdata_i == K_UNL2) ? ST_U2 : ST_READ;
      ST_U2: begin
        if (wr_en_i) begin
          st_d = ST_READ;
          if (hit_a) begin
            if (wdata_i == K_IDENT)      st_d = ST_IDENT;
            else if (wdata_i == K_PROG)  st_d = ST_PARM;
            else if (wdata_i == K_ERASE) st_d = ST_E1;
          end
        end
      end
      ST_PARM: begin
        if (wr_en_i) begin
          st_d         = ST_PBUSY;
          start_prog_o = 1'b1;
        end
      end
      ST_E1:    if (wr_en_i) st_d = (hit_a && wdata_i == K_UNL1) ? ST_E2 : ST_READ;
      ST_E2:    if (wr_en_i) st_d = (hit_b && wdata_i == K_UNL2) ? ST_E3 : ST_READ;
      ST_E3: begin
        if (wr_en_i) begin
          st_d = ST_READ;
          if (hit_a && wdata_i == K_CHIP) begin
            st_d          = ST_EBUSY;
            start_erase_o = 1'b1;
            chip_d        = 1'b1;
          end else if (wdata_i == K_SECT) begin
            st_d          = ST_EBUSY;
            start_erase_o = 1'b1;
          end
        end
      end
      ST_IDENT: if (wr_en_i && wdata_i == K_RESET) st_d = ST_READ;
      ST_PBUSY, ST_EBUSY: begin
        // completion outranks a forced timeout, which outranks suspend
        if (done_i)           st_d = ST_READ;
        else if (tmo_force_i) st_d = ST_FAIL;
        else if (st_q == ST_EBUSY && !op_chip_o && wr_en_i && wdata_i == K_SUSP)
          st_d = ST_ESUSP;
      end
      ST_ESUSP: if (wr_en_i && wdata_i == K_SECT)  st_d = ST_EBUSY;
      ST_FAIL:  if (wr_en_i && wdata_i == K_RESET) st_d = ST_READ;
      default:  st_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_READ;
      op_erase_o <= 1'b0;
      op_chip_o  <= 1'b0;
      tgt_addr_o <= '0;
      tgt_data_o <= '0;
    end else begin
      st_q <= st_d;
      if (start_prog_o) begin
        op_erase_o <= 1'b0;
        op_chip_o  <= 1'b0;
        tgt_addr_o <= addr_i;
        tgt_data_o <= wdata_i;
      end else if (start_erase_o) begin
        op_erase_o <= 1'b1;
        op_chip_o  <= chip_d;
        tgt_addr_o <= addr_i;
        tgt_data_o <= 8'hFF;
      end
    end
  end

  assign state_o = st_q;
  assign run_o   = (st_q == ST_PBUSY) || (st_q == ST_EBUSY);
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned SECT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              op_erase_i,
  input  logic              op_chip_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  logic [7:0]        tgt_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int unsigned DEPTH   = 1 << ADDR_W;
  localparam int unsigned SECT_SH = ADDR_W - SECT_W;

  logic [7:0] mem_q [DEPTH];
  logic [SECT_W-1:0] tgt_sect;

  assign tgt_sect = tgt_addr_i[ADDR_W-1 -: SECT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (commit_i) begin
      if (op_erase_i) begin
        for (int i = 0; i < DEPTH; i++)
          if (op_chip_i || (i >> SECT_SH) == int'(tgt_sect)) mem_q[i] <= 8'hFF;
      end else begin
        mem_q[tgt_addr_i] <= mem_q[tgt_addr_i] & tgt_data_i;  // cells only clear
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned SECT_W    = 3,
  parameter int unsigned PROG_CYC  = 16,
  parameter int unsigned ERASE_CYC = 64,
  parameter logic [7:0]  MFR_ID    = 8'h5A,
  parameter logic [7:0]  DEV_ID    = 8'hA7,
  parameter logic [(1<<SECT_W)-1:0] SECT_PROT = 8'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              tmo_force_i,
  output logic [7:0]        rdata_o
);
  localparam int unsigned MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  fcd_state_e        state;
  logic              start_prog, start_erase, run, commit;
  logic              op_erase, op_chip;
  logic [ADDR_W-1:0] tgt_addr;
  logic [7:0]        tgt_data, arr_rd, id_rd, rd_val;
  logic [CNT_W-1:0]  tmr_cnt, load_val;
  logic              stat_st, tgl_q;

  flash_cmd_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .tmo_force_i,
    .done_i(commit), .state_o(state),
    .start_prog_o(start_prog), .start_erase_o(start_erase), .run_o(run),
    .op_erase_o(op_erase), .op_chip_o(op_chip),
    .tgt_addr_o(tgt_addr), .tgt_data_o(tgt_data)
  );

  assign load_val = start_prog ? CNT_W'(PROG_CYC) : CNT_W'(ERASE_CYC);

  flash_op_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk_i, .rst_ni,
    .load_i(start_prog | start_erase), .load_val_i(load_val),
    .run_i(run), .done_o(commit), .cnt_o(tmr_cnt)
  );

  flash_byte_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) arr_i (
    .clk_i, .rst_ni, .commit_i(commit),
    .op_erase_i(op_erase), .op_chip_i(op_chip),
    .tgt_addr_i(tgt_addr), .tgt_data_i(tgt_data),
    .rd_addr_i(addr_i), .rd_data_o(arr_rd)
  );

  always_comb begin
    unique case (addr_i[7:0])
      8'h00:   id_rd = MFR_ID;
      8'h01:   id_rd = DEV_ID;
      8'h02:   id_rd = {7'd0, SECT_PROT[addr_i[ADDR_W-1 -: SECT_W]]};
      default: id_rd = 8'h00;
    endcase
  end

  assign stat_st = (state == ST_PBUSY) || (state == ST_EBUSY) || (state == ST_FAIL);

  always_comb begin
    if (stat_st)                rd_val = {(op_erase ? 1'b0 : ~tgt_data[7]), tgl_q,
                                          (state == ST_FAIL), 5'd0};
    else if (state == ST_IDENT) rd_val = id_rd;
    else                        rd_val = arr_rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= 8'h00;
      tgl_q   <= 1'b0;
    end else begin
      if (rd_en_i) rdata_o <= rd_val;
      if (!stat_st)     tgl_q <= 1'b0;
      else if (rd_en_i) tgl_q <= ~tgl_q;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk
  import flash_cmd_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [7:0]       wdata_i,
  input logic             tmo_force_i,
  input logic [7:0]       rdata_o,
  input fcd_state_e       state_i,
  input logic             commit_i,
  input logic [CNT_W-1:0] cnt_i
);
  assert_rd_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  assert_commit_ret_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> state_i == ST_READ);

  assert_ident_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDENT && !(wr_en_i && wdata_i == 8'hF0)) |=> state_i == ST_IDENT);

  assert_status_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (state_i == ST_PBUSY || state_i == ST_EBUSY))
      |=> (rdata_o[5] == 1'b0 && rdata_o[4:0] == 5'd0));

  assert_susp_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_ESUSP |=> $stable(cnt_i));

  assert_fail_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FAIL && !(wr_en_i && wdata_i == 8'hF0)) |=> state_i == ST_FAIL);

  assert_fail_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FAIL && rd_en_i) |=> rdata_o[5]);

  assert_done_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && tmo_force_i) |=> state_i != ST_FAIL);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .wdata_i(wdata_i), .tmo_force_i(tmo_force_i), .rdata_o(rdata_o),
  .state_i(state), .commit_i(commit), .cnt_i(tmr_cnt)
);

// File: tb/flash_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;
  localparam int AW = 11;
  localparam int PCYC = 16;
  localparam int ECYC = 64;
  localparam logic [7:0] MFR = 8'h5A;
  localparam logic [7:0] DEV = 8'hA7;
  localparam logic [7:0] PROT = 8'h04;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0, tmo = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;
  int total = 0, bad = 0;
  string cur_req = "R1";
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wd), .tmo_force_i(tmo), .rdata_o(rdata)
  );

  // behavioural reference: modes as integers, array as plain bytes
  localparam int M_RD = 0, M_U1 = 1, M_U2 = 2, M_PA = 3, M_E1 = 4, M_E2 = 5, M_E3 = 6;
  localparam int M_ID = 7, M_PB = 8, M_EB = 9, M_SU = 10, M_FL = 11;
  int m_st, m_cnt, m_tgt;
  bit m_tgl, m_era, m_chip;
  logic [7:0] m_dat, m_rd;
  logic [7:0] m_mem [2048];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = M_RD; m_cnt = 0; m_tgt = 0; m_tgl = 0; m_era = 0; m_chip = 0;
      m_dat = 0; m_rd = 8'h00;
      foreach (m_mem[k]) m_mem[k] = 8'hFF;
    end else begin
      automatic bit busy = (m_st == M_PB || m_st == M_EB || m_st == M_FL);
      automatic bit a5 = (addr == 11'h555), a2 = (addr == 11'h2AA);
      if (rd) begin
        if (busy) m_rd = {(m_era ? 1'b0 : ~m_dat[7]), m_tgl, (m_st == M_FL), 5'd0};
        else if (m_st == M_ID) begin
          if (addr[7:0] == 0) m_rd = MFR;
          else if (addr[7:0] == 1) m_rd = DEV;
          else if (addr[7:0] == 2) m_rd = {7'd0, PROT[addr[10:8]]};
          else m_rd = 8'h00;
        end else m_rd = m_mem[addr];
      end
      if (!busy) m_tgl = 0;
      else if (rd) m_tgl = ~m_tgl;
      case (m_st)
        M_RD: if (wr && a5 && wd == 8'hAA) m_st = M_U1;
        M_U1: if (wr) m_st = (a2 && wd == 8'h55) ? M_U2 : M_RD;
        M_U2: if (wr) m_st = !a5 ? M_RD : wd == 8'h90 ? M_ID : wd == 8'hA0 ? M_PA :
                              wd == 8'h80 ? M_E1 : M_RD;
        M_PA: if (wr) begin m_st = M_PB; m_tgt = addr; m_dat = wd; m_era = 0; m_chip = 0; m_cnt = PCYC; end
        M_E1: if (wr) m_st = (a5 && wd == 8'hAA) ? M_E2 : M_RD;
        M_E2: if (wr) m_st = (a2 && wd == 8'h55) ? M_E3 : M_RD;
        M_E3: if (wr) begin
          if ((a5 && wd == 8'h10) || wd == 8'h30) begin
            m_st = M_EB; m_era = 1; m_chip = (a5 && wd == 8'h10); m_tgt = addr;
            m_dat = 8'hFF; m_cnt = ECYC;
          end else m_st = M_RD;
        end
        M_ID: if (wr && wd == 8'hF0) m_st = M_RD;
        M_PB, M_EB: begin
          if (m_cnt == 1) begin
            if (!m_era) m_mem[m_tgt] = m_mem[m_tgt] & m_dat;
            else foreach (m_mem[k]) if (m_chip || (k >> 8) == (m_tgt >> 8)) m_mem[k] = 8'hFF;
            m_st = M_RD;
          end else if (tmo) m_st = M_FL;
          else begin
            m_cnt--;
            if (m_st == M_EB && !m_chip && wr && wd == 8'hB0) m_st = M_SU;
          end
        end
        M_SU: if (wr && wd == 8'h30) m_st = M_EB;
        M_FL: if (wr && wd == 8'hF0) m_st = M_RD;
        default: m_st = M_RD;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      total++;
      if (rdata !== m_rd) begin
        bad++;
        $display("FAIL %s model compare: actual=%02h expected=%02h", cur_req, rdata, m_rd);
      end
    end
  end

  task automatic cyc(input bit w, input bit r, input logic [AW-1:0] a,
                     input logic [7:0] d, input bit t);
    @(negedge clk);
    wr = w; rd = r; addr = a; wd = d; tmo = t;
    @(posedge clk);
    #1;
    wr = 0; rd = 0; tmo = 0;
  endtask

  task automatic wrc(input logic [AW-1:0] a, input logic [7:0] d);
    cyc(1, 0, a, d, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) cyc(0, 0, '0, '0, 0);
  endtask

  task automatic rdchk(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    cyc(0, 1, a, '0, 0);
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL %s read %03h: actual=%02h expected=%02h", req, a, rdata, exp);
    end
  endtask

  task automatic unlock();
    wrc(11'h555, 8'hAA); wrc(11'h2AA, 8'h55);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    unlock(); wrc(11'h555, 8'hA0); wrc(a, d);
  endtask

  task automatic erase_pre();
    unlock(); wrc(11'h555, 8'h80); unlock();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (rdata !== 8'h00) begin
      bad++;
      $display("FAIL R1 reset output: actual=%02h expected=00", rdata);
    end
    rst_n = 1;
    cur_req = "R1";
    rdchk(11'h000, 8'hFF, "R1");
    rdchk(11'h7FF, 8'hFF, "R1");
    idle(2);

    cur_req = "R2";
    prog(11'h123, 8'h5A);
    rdchk(11'h123, 8'h80, "R8");   // ~bit7 of 5Ah, toggle 0
    rdchk(11'h000, 8'hC0, "R8");   // toggle flipped
    idle(PCYC);
    rdchk(11'h123, 8'h5A, "R2");

    cur_req = "R3";
    prog(11'h123, 8'hF0);
    idle(PCYC + 2);
    rdchk(11'h123, 8'h50, "R3");

    cur_req = "R4";
    unlock(); wrc(11'h555, 8'h90);
    rdchk(11'h000, MFR, "R4");
    rdchk(11'h101, DEV, "R4");
    rdchk(11'h202, 8'h01, "R4");
    rdchk(11'h302, 8'h00, "R4");
    rdchk(11'h005, 8'h00, "R4");
    wrc(11'h555, 8'hAA);
    rdchk(11'h000, MFR, "R4");
    wrc(11'h000, 8'hF0);
    rdchk(11'h123, 8'h50, "R4");

    cur_req = "R7";
    unlock(); wrc(11'h554, 8'hA0); wrc(11'h123, 8'h00);
    rdchk(11'h123, 8'h50, "R7");
    wrc(11'h555, 8'hAA); wrc(11'h000, 8'hF0);
    wrc(11'h2AA, 8'h55); wrc(11'h555, 8'hA0); wrc(11'h123, 8'h00);
    idle(PCYC + 2);
    rdchk(11'h123, 8'h50, "R7");

    cur_req = "R6";
    prog(11'h1A0, 8'h00); idle(PCYC + 1);
    prog(11'h2A0, 8'h11); idle(PCYC + 1);
    erase_pre(); wrc(11'h155, 8'h30);
    rdchk(11'h155, 8'h00, "R8");
    rdchk(11'h155, 8'h40, "R8");
    cur_req = "R9";
    wrc(11'h000, 8'hB0);
    idle(ECYC + 5);
    rdchk(11'h123, 8'h50, "R9");   // suspended: array visible, not erased
    wrc(11'h000, 8'h00);
    rdchk(11'h1A0, 8'h00, "R9");
    wrc(11'h000, 8'h30);
    idle(ECYC);
    cur_req = "R6";
    rdchk(11'h123, 8'hFF, "R6");
    rdchk(11'h1A0, 8'hFF, "R6");
    rdchk(11'h2A0, 8'h11, "R6");

    cur_req = "R10";
    prog(11'h2A0, 8'h01);
    rdchk(11'h2A0, 8'h80, "R10");
    cyc(0, 0, '0, '0, 1);
    rdchk(11'h2A0, 8'hE0, "R10");
    wrc(11'h000, 8'h00);
    idle(PCYC + 2);
    rdchk(11'h2A0, 8'hA0, "R10");
    wrc(11'h000, 8'hF0);
    rdchk(11'h2A0, 8'h11, "R10");

    cur_req = "R11";
    prog(11'h2A1, 8'h3C);
    idle(PCYC - 1);
    cyc(0, 0, '0, '0, 1);          // last busy cycle
    rdchk(11'h2A1, 8'h3C, "R11");

    cur_req = "R5";
    erase_pre(); wrc(11'h555, 8'h10);
    idle(ECYC);
    rdchk(11'h2A1, 8'hFF, "R5");
    rdchk(11'h2A0, 8'hFF, "R5");
    rdchk(11'h000, 8'hFF, "R5");

    idle(2);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule